// File: doc/BRIEF.md
# Serial Link Packet Receiver

This block receives a single-wire serial link whose transitions bear no phase relation to the local clock. The line rests low. Every packet opens with a high start bit, and the bit after it gives the packet type. A high type bit introduces a data byte: eight bits follow, lowest first, and then a low stop bit, for eleven bits in all. A low type bit ends the packet at two bits, and that packet is an acknowledge.

Data bytes go into a one-entry buffer, and a valid flag is raised when they arrive. The consumer drops the flag with a one-cycle take strobe. An acknowledge never reaches the buffer. It produces a one-cycle pulse that the neighbouring transmitter uses to release its next byte.

The line passes through a two-flop synchronizer. Bits are sampled at their centres, with the timing counted from the detected rising edge of the start bit. Two bit lengths, set by parameters, are chosen by a speed select that is captured at each start bit.

Top module: `link_rx`

## Requirements
- R1: While reset is active and in the first cycle after it, `rx_valid`, `ack_pulse` and `frame_err` are all 0.
- R2: A packet of bit sequence 1 (start), 1 (type), d0..d7 (least significant first), 0 (stop) loads d7..d0 into `rx_byte` and sets `rx_valid` to 1.
- R3: A packet of sequence 1 (start), 0 (type) gives `ack_pulse` high for exactly one cycle, and leaves `rx_byte` and `rx_valid` unchanged.
- R4: If the stop bit of a data packet is 1, `frame_err` is high for one cycle, the byte is dropped (`rx_byte` and `rx_valid` unchanged), and the receiver goes back to hunting for a start bit.
- R5: `rx_valid` rises within 14 bit times of the rising edge of a data packet's start bit.
- R6: When `speed_hi` is 1 at the start bit, one bit lasts DIV_FAST clocks; when it is 0, DIV_SLOW clocks. A change of `speed_hi` in the middle of a packet does not affect that packet.
- R7: A one-cycle `rx_take` clears `rx_valid` on the next clock edge.
- R8: After a packet, the receiver does not look for a new start bit until the line has been seen low. A line that stays high after a failed stop bit therefore produces no further packet.
- R9: `ack_pulse` and `frame_err` are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_hi | input | 1 | 1 selects the short bit length DIV_FAST, 0 selects DIV_SLOW |
| line_in | input | 1 | Asynchronous serial input, idle low |
| rx_take | input | 1 | Consumer strobe that empties the buffer |
| rx_byte | output | 8 | Last good data byte received |
| rx_valid | output | 1 | Buffer holds an unread byte |
| ack_pulse | output | 1 | One-cycle pulse per acknowledge packet |
| frame_err | output | 1 | One-cycle pulse per data packet with a bad stop bit |

## Verification
The assertions assume three things. Every bit on the line is held for the bit length that was selected at its start bit. The line goes low at some point between packets. `rx_take` is not asserted in the cycle in which a byte is stored. The bench meets these by driving the line only at falling clock edges for whole bit lengths, by leaving a low gap after each packet, and by strobing take only after a packet has fully settled. The one exception is the back-to-back case, where the low type bit of the acknowledge is itself the gap.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
  typedef enum logic [2:0] {
    ST_WAITLOW,
    ST_HUNT,
    ST_TYPE,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  // Clocks from the detected start edge to the centre of the type bit, minus one.
  function automatic int unsigned first_gap(input int unsigned div);
    return div + div / 2 - 1;
  endfunction

  // Clocks between later samples, minus one.
  function automatic int unsigned next_gap(input int unsigned div);
    return div - 1;
  endfunction
endpackage

// File: rtl/link_rx_sync.sv
module link_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/link_rx_timer.sv
module link_rx_timer
  import link_rx_pkg::*;
#(
  parameter int DW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [DW-1:0] sel_div,
  output logic          tick,
  output logic [DW-1:0] div_q
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else if (load) begin
      div_q <= sel_div;
      cnt   <= CW'(first_gap(32'(sel_div)));
    end else if (run) begin
      if (cnt == '0) cnt <= CW'(next_gap(32'(div_q)));
      else           cnt <= cnt - CW'(1);
    end
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/link_rx_frame.sv
module link_rx_frame
  import link_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_s,
  input  logic                 tick,
  output logic                 start_evt,
  output logic                 run,
  output logic                 store_evt,
  output logic [DATA_BITS-1:0] shift_byte,
  output logic                 ack_pulse,
  output logic                 frame_err
);
  localparam int IW = $clog2(DATA_BITS);

  rx_state_e      state;
  logic [IW-1:0]  idx;

  always_comb begin
    start_evt = (state == ST_HUNT) && line_s;
    run       = (state == ST_TYPE) || (state == ST_DATA) || (state == ST_STOP);
    store_evt = tick && (state == ST_STOP) && !line_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_WAITLOW;
      idx        <= '0;
      shift_byte <= '0;
      ack_pulse  <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      ack_pulse <= 1'b0;
      frame_err <= 1'b0;
      case (state)
        ST_WAITLOW: if (!line_s) state <= ST_HUNT;
        ST_HUNT:    if (line_s)  state <= ST_TYPE;
        ST_TYPE: if (tick) begin
          if (line_s) begin
            state <= ST_DATA;
            idx   <= '0;
          end else begin
            ack_pulse <= 1'b1;
            state     <= ST_WAITLOW;
          end
        end
        ST_DATA: if (tick) begin
          shift_byte <= {line_s, shift_byte[DATA_BITS-1:1]};
          if (idx == IW'(DATA_BITS - 1)) state <= ST_STOP;
          else                           idx   <= idx + IW'(1);
        end
        ST_STOP: if (tick) begin
          if (line_s) frame_err <= 1'b1;
          state <= ST_WAITLOW;
        end
        default: state <= ST_WAITLOW;
      endcase
    end
  end
endmodule

// File: rtl/link_rx_buf.sv
module link_rx_buf #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 store,
  input  logic [DATA_BITS-1:0] din,
  input  logic                 take,
  output logic [DATA_BITS-1:0] dout,
  output logic                 valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else if (store) begin
      dout  <= din;
      valid <= 1'b1;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/link_rx.sv
module link_rx
  import link_rx_pkg::*;
#(
  parameter int DIV_SLOW  = 8,
  parameter int DIV_FAST  = 4,
  parameter int DATA_BITS = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 speed_hi,
  input  logic                 line_in,
  input  logic                 rx_take,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 ack_pulse,
  output logic                 frame_err
);
  localparam int DW = $clog2(DIV_SLOW + 1);
  localparam int CW = $clog2(DIV_SLOW + DIV_SLOW / 2 + 1);

  logic                 line_s;
  logic                 tick;
  logic                 start_evt;
  logic                 run;
  logic                 store_evt;
  logic [DATA_BITS-1:0] shift_byte;
  logic [DW-1:0]        sel_div;
  logic [DW-1:0]        div_q;

  assign sel_div = speed_hi ? DW'(DIV_FAST) : DW'(DIV_SLOW);

  link_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  link_rx_timer #(.DW(DW), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .run(run),
    .sel_div(sel_div), .tick(tick), .div_q(div_q)
  );

  link_rx_frame #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .tick(tick),
    .start_evt(start_evt), .run(run), .store_evt(store_evt),
    .shift_byte(shift_byte), .ack_pulse(ack_pulse), .frame_err(frame_err)
  );

  link_rx_buf #(.DATA_BITS(DATA_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .store(store_evt), .din(shift_byte),
    .take(rx_take), .dout(rx_byte), .valid(rx_valid)
  );
endmodule

// File: rtl/link_rx_chk.sv
module link_rx_chk #(
  parameter int DW        = 4,
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ack_pulse,
  input logic                 frame_err,
  input logic                 rx_valid,
  input logic                 rx_take,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 store_evt,
  input logic                 start_evt,
  input logic [DW-1:0]        div_q
);
  logic [9:0] since_start;

  always_ff @(posedge clk) begin
    if (!rst_n)              since_start <= '0;
    else if (start_evt)      since_start <= '0;
    else if (since_start != '1) since_start <= since_start + 10'd1;
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_pulse && frame_err));
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |=> !ack_pulse);
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  a_r3_ack_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> ($stable(rx_byte) && !$rose(rx_valid)));
  a_r4_err_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($stable(rx_byte) && !$rose(rx_valid)));
  a_r2_store_sets: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> rx_valid);
  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && !store_evt) |=> !rx_valid);
  a_r5_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |-> (since_start < 10'd14 * 10'(div_q)));
endmodule

bind link_rx link_rx_chk #(.DW(DW), .DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_pulse(ack_pulse), .frame_err(frame_err),
  .rx_valid(rx_valid), .rx_take(rx_take), .rx_byte(rx_byte),
  .store_evt(store_evt), .start_evt(start_evt), .div_q(div_q)
);

// File: tb/link_rx_test.sv
`timescale 1ns/1ps
module link_rx_test;
  localparam int SLOW = 8;
  localparam int FAST = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_hi = 1'b0;
  logic       line_in = 1'b0;
  logic       rx_take = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       ack_pulse;
  logic       frame_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int ack_cnt = 0;
  int err_cnt = 0;
  int t_start = 0;
  int t_valid = -1;
  logic v_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_rx #(.DIV_SLOW(SLOW), .DIV_FAST(FAST)) uut (
    .clk(clk), .rst_n(rst_n), .speed_hi(speed_hi), .line_in(line_in),
    .rx_take(rx_take), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .ack_pulse(ack_pulse), .frame_err(frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ack_pulse) ack_cnt++;
    if (frame_err) err_cnt++;
    if (rx_valid && !v_prev) t_valid = cyc;
    v_prev = rx_valid;
  end

  // Fields of each vector: [10] data packet, [9] stop bit value, [8] speed_hi, [7:0] byte
  localparam logic [10:0] VEC [8] = '{
    11'h4A5, 11'h53C, 11'h000, 11'h100, 11'h6FF, 11'h500, 11'h481, 11'h75A
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input bit v, input int div);
    line_in = v;
    repeat (div) @(negedge clk);
  endtask

  task automatic send_frame(input bit is_data, input logic [7:0] b, input bit stop_v,
                            input bit hi, input bit flip, input int tail_high, input int gap);
    int div;
    div = hi ? FAST : SLOW;
    speed_hi = hi;
    t_start = cyc;
    drive_bit(1'b1, div);
    if (flip) speed_hi = ~hi;
    drive_bit(is_data, div);
    if (is_data) begin
      for (int k = 0; k < 8; k++) drive_bit(b[k], div);
      drive_bit(stop_v, div);
    end
    if (tail_high > 0) drive_bit(1'b1, tail_high * div);
    line_in = 1'b0;
    if (gap > 0) repeat (gap * div) @(negedge clk);
  endtask

  task automatic take_byte();
    rx_take = 1'b1;
    @(negedge clk);
    rx_take = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_byte;
    int a0, e0;
    exp_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
    chk(ack_pulse == 1'b0 && frame_err == 1'b0, "R1 pulses in reset", {ack_pulse, frame_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
    repeat (4) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      int div;
      v = VEC[i];
      div = v[8] ? FAST : SLOW;
      a0 = ack_cnt;
      e0 = err_cnt;
      t_valid = -1;
      send_frame(v[10], v[7:0], v[9], v[8], 1'b0, 0, 3);
      if (v[10] && !v[9]) begin
        exp_byte = v[7:0];
        chk(rx_valid == 1'b1, "R2 valid set", rx_valid, 1);
        chk(rx_byte == exp_byte, "R2 byte (R6 speed)", rx_byte, exp_byte);
        chk(t_valid >= 0 && (t_valid - t_start) <= 14 * div, "R5 latency",
            t_valid - t_start, 14 * div);
        chk(err_cnt == e0, "R4 no false error", err_cnt, e0);
        take_byte();
        chk(rx_valid == 1'b0, "R7 take clears", rx_valid, 0);
      end else if (v[10]) begin
        chk(err_cnt == e0 + 1, "R4 error pulse", err_cnt, e0 + 1);
        chk(rx_valid == 1'b0, "R4 no store", rx_valid, 0);
        chk(rx_byte == exp_byte, "R4 byte kept", rx_byte, exp_byte);
      end else begin
        chk(ack_cnt == a0 + 1, "R3 R9 one ack pulse", ack_cnt, a0 + 1);
        chk(rx_valid == 1'b0, "R3 no valid", rx_valid, 0);
        chk(rx_byte == exp_byte, "R3 byte kept", rx_byte, exp_byte);
      end
    end

    // R6: speed select flipped after the start bit is ignored for this packet
    send_frame(1'b1, 8'hC6, 1'b0, 1'b0, 1'b1, 0, 3);
    chk(rx_valid == 1'b1 && rx_byte == 8'hC6, "R6 mid-packet speed change", rx_byte, 8'hC6);
    take_byte();

    // R8: bad stop followed by line held high for 4 bits yields nothing more
    a0 = ack_cnt;
    e0 = err_cnt;
    send_frame(1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 4, 3);
    chk(err_cnt == e0 + 1, "R8 single error", err_cnt, e0 + 1);
    chk(ack_cnt == a0, "R8 no phantom ack", ack_cnt, a0);
    chk(rx_valid == 1'b0, "R8 no phantom byte", rx_valid, 0);

    // R3/R2: acknowledge immediately followed by a data packet
    a0 = ack_cnt;
    send_frame(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 0, 0);
    send_frame(1'b1, 8'h96, 1'b0, 1'b1, 1'b0, 0, 3);
    chk(ack_cnt == a0 + 1, "R3 back-to-back ack", ack_cnt, a0 + 1);
    chk(rx_valid == 1'b1 && rx_byte == 8'h96, "R2 back-to-back data", rx_byte, 8'h96);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule